// File: doc/BRIEF.md
# Dual-Channel Quadrature Glitch Filter

This block cleans the two channels of a quadrature encoder, A and B, before they reach a decoder. The raw pins are asynchronous. On every rising edge of the system clock, each channel is sampled into its own four-stage shift register. The first stage of that register also serves as the synchronizer. The three stages behind it are the qualifying window.

A small two-state machine per channel drives the filtered output. It behaves like a JK flip-flop:

- It moves to the high state when all three qualifying samples are 1.
- It moves to the low state when all three are 0.
- For any mixed window it holds its present state.

As a result, a spike that falls between clock edges is never seen. A pulse seen by only one or two samples is dropped. A level held for three samples passes, after a fixed latency of five rising edges. That count starts with the first edge that samples the new level.

The two channels are built from the same channel module. They share no state. Both states and their transitions are named:

| State | Meaning |
|---|---|
| `HOLD_LOW` | The filtered output is 0. |
| `HOLD_HIGH` | The filtered output is 1. |

| Transition | From | To | Condition |
|---|---|---|---|
| `GO_HIGH` | `HOLD_LOW` | `HOLD_HIGH` | The window is all 1s. |
| `GO_LOW` | `HOLD_HIGH` | `HOLD_LOW` | The window is all 0s. |
| `STAY` | either state | the same state | Any other window. |

Top module: `quad_glitch_filter`

## Requirements
- R1: While the active-low reset is asserted, both filtered outputs and every history bit are 0.
- R2: Inputs are sampled only at rising clock edges. A glitch that begins and ends between two rising edges leaves the outputs unchanged.
- R3: A filtered output goes from 0 to 1 only when the three qualifying samples (history stages 1 to 3, stage 0 being the synchronizer) are all 1.
- R4: A filtered output goes from 1 to 0 only when the three qualifying samples are all 0.
- R5: When the qualifying samples disagree, the filtered output keeps its previous value.
- R6: An input pulse captured by a single sample never reaches the output, and the output never changes twice within three consecutive clock cycles.
- R7: A pulse held for two samples, and an alternating 1-0-1 pattern, are both rejected.
- R8: A clean level change that is first captured at rising edge k appears on the output just after rising edge k+4, that is, five edges counting edge k.
- R9: Channels A and B are filtered independently: activity on one never changes the other's output.
- R10: After reset is released with the inputs held low, no output transition appears while the history refills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; everything changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a_raw | input | 1 | Raw, asynchronous encoder channel A |
| enc_b_raw | input | 1 | Raw, asynchronous encoder channel B |
| enc_a_clean | output | 1 | Filtered channel A |
| enc_b_clean | output | 1 | Filtered channel B |

## Verification
The assertions take for granted that reset is released away from a clock edge. They also assume the raw inputs settle before each sampling edge, so that the synchronizer stage holds a defined 0 or 1. Within the bench no metastability is modelled.

The stimulus meets these assumptions:

- It changes the pins only near the falling edge of the clock.
- Deliberate glitches are placed strictly inside the low half of the period, and they return to the driven level before the next rising edge.
- Reset is dropped on a falling edge while both inputs are low.

// File: rtl/qf_pkg.sv
package qf_pkg;
    typedef enum logic {
        HOLD_LOW  = 1'b0,
        HOLD_HIGH = 1'b1
    } hold_state_t;
endpackage

// File: rtl/qf_history.sv
module qf_history #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);
    logic [DEPTH-1:0] shreg;

    // Stage 0 captures the asynchronous pin; later stages age it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[DEPTH-2:0], din};
        end
    end

    assign taps = shreg;

`ifndef SYNTHESIS
    // R1: history empty after reset edge
    assert_hist_clear_R1: assert property (@(posedge clk)
        disable iff (!rst_n) $rose(rst_n) |-> (shreg[DEPTH-1:1] == '0));
`endif
endmodule

// File: rtl/qf_holdstage.sv
module qf_holdstage
    import qf_pkg::*;
#(
    parameter int QUAL = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [QUAL-1:0] window,
    output logic            q
);
    hold_state_t state_r;
    hold_state_t state_n;
    logic        all_hi;
    logic        all_lo;

    assign all_hi = &window;
    assign all_lo = ~|window;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_r <= HOLD_LOW;
        end else begin
            state_r <= state_n;
        end
    end

    // Transitions: GO_HIGH, GO_LOW, STAY
    always_comb begin
        state_n = state_r;
        unique case (state_r)
            HOLD_LOW:  if (all_hi) state_n = HOLD_HIGH;
            HOLD_HIGH: if (all_lo) state_n = HOLD_LOW;
            default:   state_n = HOLD_LOW;
        endcase
    end

    // Output process
    always_comb begin
        unique case (state_r)
            HOLD_HIGH: q = 1'b1;
            default:   q = 1'b0;
        endcase
    end

`ifndef SYNTHESIS
    assert_rise_on_agree_R3: assert property (@(posedge clk)
        disable iff (!rst_n) $rose(q) |-> $past(window) == {QUAL{1'b1}});

    assert_fall_on_agree_R4: assert property (@(posedge clk)
        disable iff (!rst_n) $fell(q) |-> $past(window) == '0);

    assert_hold_on_mix_R5: assert property (@(posedge clk)
        disable iff (!rst_n)
        ((window != '0) && (window != {QUAL{1'b1}})) |=> $stable(q));
`endif
endmodule

// File: rtl/qf_channel.sv
module qf_channel #(
    parameter int SYNC_STAGES  = 1,
    parameter int QUAL_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int DEPTH = SYNC_STAGES + QUAL_SAMPLES;

    logic [DEPTH-1:0] taps;

    qf_history #(.DEPTH(DEPTH)) hist_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .taps (taps)
    );

    qf_holdstage #(.QUAL(QUAL_SAMPLES)) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .window(taps[DEPTH-1:SYNC_STAGES]),
        .q     (clean_out)
    );

`ifndef SYNTHESIS
    // R6: once the output moves, it cannot move again for two further cycles
    assert_min_pulse_R6: assert property (@(posedge clk)
        disable iff (!rst_n)
        (clean_out != $past(clean_out)) |=> $stable(clean_out) ##1 $stable(clean_out));
`endif
endmodule

// File: rtl/quad_glitch_filter.sv
module quad_glitch_filter #(
    parameter int SYNC_STAGES  = 1,
    parameter int QUAL_SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a_raw,
    input  logic enc_b_raw,
    output logic enc_a_clean,
    output logic enc_b_clean
);
    localparam int NUM_CH  = 2;
    localparam int LATENCY = SYNC_STAGES + QUAL_SAMPLES + 1;

    logic [NUM_CH-1:0] raw_vec;
    logic [NUM_CH-1:0] clean_vec;

    assign raw_vec = {enc_b_raw, enc_a_raw};

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
            qf_channel #(
                .SYNC_STAGES (SYNC_STAGES),
                .QUAL_SAMPLES(QUAL_SAMPLES)
            ) chan_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .raw_in   (raw_vec[ch]),
                .clean_out(clean_vec[ch])
            );
        end
    endgenerate

    assign enc_a_clean = clean_vec[0];
    assign enc_b_clean = clean_vec[1];

`ifndef SYNTHESIS
    initial begin
        assert_latency_sane_R8: assert (LATENCY >= 3);
    end
`endif
endmodule

// File: tb/quad_glitch_filter_tb.sv
`timescale 1ns/100ps
module quad_glitch_filter_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_raw = 1'b0;
    logic b_raw = 1'b0;
    logic a_cln;
    logic b_cln;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  ea;
        logic  eb;
        string tag;
    } exp_t;

    exp_t sb[$];

    logic [3:0] ha = '0;
    logic [3:0] hb = '0;
    logic       qa = 1'b0;
    logic       qb = 1'b0;

    always #2 clk = ~clk;

    quad_glitch_filter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_a_raw  (a_raw),
        .enc_b_raw  (b_raw),
        .enc_a_clean(a_cln),
        .enc_b_clean(b_cln)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Output after an edge follows the three oldest qualifying samples.
    function automatic logic model_q(input logic [3:0] h, input logic q_old);
        if (h[3] && h[2] && h[1]) return 1'b1;
        if (!h[3] && !h[2] && !h[1]) return 1'b0;
        return q_old;
    endfunction

    // Driver: one call per clock cycle; optional mid-cycle glitch
    task automatic step(input logic va, input logic vb, input bit glitch, input string tag);
        exp_t it;
        @(negedge clk);
        a_raw = va;
        b_raw = vb;
        qa = model_q(ha, qa);
        qb = model_q(hb, qb);
        ha = {ha[2:0], va};
        hb = {hb[2:0], vb};
        it.ea = qa;
        it.eb = qb;
        it.tag = tag;
        sb.push_back(it);
        if (glitch) begin
            #0.5 a_raw = ~va; b_raw = ~vb;
            #0.6 a_raw = va;  b_raw = vb;
        end
    endtask

    // Monitor
    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check(it.tag, a_cln, it.ea, "chan A");
            check(it.tag, b_cln, it.eb, "chan B");
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", a_cln, 1'b0, "reset A");
        check("R1", b_cln, 1'b0, "reset B");
        @(negedge clk);
        rst_n = 1'b1;

        // R10: refill with low inputs, no spurious edge
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, "R10");
        // R2: glitches strictly between edges
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b1, "R2");
        // R6: single-sample spike on A
        step(1'b1, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, "R6");
        // R7: two-sample pulse, then alternating 1-0-1
        step(1'b1, 1'b0, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 7; i++) step(1'((i + 1) % 2), 1'b0, 1'b0, "R7");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, "R7");
        // R3, R8, R9: A steps high, B stays low
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, "R3_R8_R9");
        // R5: mixed samples while high
        step(1'b0, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, "R5");
        // R4, R9: A falls while B rises
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b0, "R4_R9");
        // R2 while high on B, spike on B rejected while low on A
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, "R2");
        step(1'b1, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 1'b0, "R6");
        // R8: B falls, exact timing
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, "R8");

        wait (sb.size() == 0);
        @(posedge clk);
        #2;
        finish_run();
    end
endmodule